// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. It drives three analog switch controls and measures time with one counter. A start request in idle begins a conversion with three phases in a fixed order. First it connects the integrator to the unknown input for a fixed number of clock ticks. Next it connects the integrator to the reference and counts ticks until the external zero-crossing comparator reports that the integrator is back at zero. Last it shorts the integrating capacitor for a fixed number of ticks and then returns to idle.

The number of ticks counted in the reference phase is the conversion result. It scales with the input as a fraction of the reference, multiplied by the fixed input-phase length. The result register changes only when a measurement ends, and a one-cycle done pulse marks the update. If the comparator never fires within a parameterised tick limit, the count saturates and an overrange flag is latched along with the result. Only one input polarity is handled.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is active and in the cycles after it, all three switch outputs, `busy_o`, `done_o` and `over_o` are 0, and `result_o` is 0.
- R2: A high `start_i` sampled in idle begins the input phase. In this phase only `sw_input_o` is high, and it lasts exactly `T1_TICKS` clock cycles.
- R3: The reference phase follows the input phase, with only `sw_ref_o` high. `result_o` (unsigned binary) becomes the number of reference-phase cycles that came before the first cycle in which `zero_cross_i` was sampled high.
- R4: While `busy_o` is high exactly one switch output is high. In idle none is high.
- R5: `result_o` and `over_o` change only at the end of a reference phase. `done_o` is high for exactly one cycle per conversion, in the first cycle of the discharge phase, and the new result is visible in that same cycle.
- R6: If `zero_cross_i` stays low through the reference cycles with counts 0 to `T2_MAX`, then `result_o` = `T2_MAX` and `over_o` = 1. A crossing seen at count `T2_MAX` gives `T2_MAX` with `over_o` = 0. The next in-range result clears `over_o`.
- R7: The discharge phase has only `sw_dump_o` high, lasts exactly `RST_TICKS` cycles, and is followed by idle.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: A conversion keeps `busy_o` high for `T1_TICKS` + (reference cycles) + `RST_TICKS` cycles. The reference cycles are `result_o`+1 for an in-range result and `T2_MAX`+1 on overrange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, taken in idle only |
| zero_cross_i | input | 1 | Comparator: integrator has returned to zero |
| sw_input_o | output | 1 | Connect the integrator to the unknown input |
| sw_ref_o | output | 1 | Connect the integrator to the reference |
| sw_dump_o | output | 1 | Short the integrating capacitor |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is latched |
| result_o | output | CNT_W | Latched reference-phase tick count |
| over_o | output | 1 | Latched overrange flag |

## Verification
The bench builds the block with `T1_TICKS` = 1000, `T2_MAX` = 1023, `RST_TICKS` = 4 and a 10-bit count. It closes the loop with an arithmetic integrator model whose reference equals 800 input units. Under this model full scale gives 1000 and half scale gives 500, while small inputs give rounded-up counts. Inputs of 818 and 819 reach exactly the count limit and one past it, so the saturation boundary is tested on both sides. A dense sweep of small inputs, together with these spot values, fits in well under the cycle budget. It also covers phase lengths, busy time and a start pulse injected during a conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2,
    PH_DISCH = 2'd3
  } phase_t;
endpackage

// File: rtl/dsadc_rst_sync.sv
module dsadc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_tick_cnt.sv
module dsadc_tick_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R6: count never passes all-ones (phase limits stop it first)
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int T1_TICKS  = 1000,
  parameter int T2_MAX    = 1023,
  parameter int RST_TICKS = 4,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] cnt_i,
  output phase_t           phase_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             latch_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] T1_LAST  = CNT_W'(T1_TICKS - 1);
  localparam logic [CNT_W-1:0] T2_LAST  = CNT_W'(T2_MAX);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);

  phase_t ph_q, ph_d;

  always_comb begin
    ph_d      = ph_q;
    cnt_clr_o = 1'b0;
    latch_o   = 1'b0;
    ovf_o     = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        cnt_clr_o = 1'b1;
        if (start_i) ph_d = PH_INTEG;
      end
      PH_INTEG: begin
        if (cnt_i == T1_LAST) begin
          ph_d      = PH_DEINT;
          cnt_clr_o = 1'b1;
        end
      end
      PH_DEINT: begin
        if (zero_i) begin
          latch_o   = 1'b1;
          ph_d      = PH_DISCH;
          cnt_clr_o = 1'b1;
        end else if (cnt_i == T2_LAST) begin
          latch_o   = 1'b1;
          ovf_o     = 1'b1;
          ph_d      = PH_DISCH;
          cnt_clr_o = 1'b1;
        end
      end
      PH_DISCH: begin
        if (cnt_i == RST_LAST) begin
          ph_d      = PH_IDLE;
          cnt_clr_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase_o  = ph_q;
  assign cnt_en_o = (ph_q != PH_IDLE);

  // R2: a start in idle enters the input phase
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && start_i) |=> ph_q == PH_INTEG);
  // R8: a start outside idle never sends the sequencer back to the input phase
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEINT && start_i) |=> ph_q != PH_INTEG);
  // R7: discharge always ends in idle, never in another phase
  a_r7_disch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DISCH && ph_d != PH_DISCH) |=> ph_q == PH_IDLE);
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             ovf_i,
  output logic [CNT_W-1:0] result_o,
  output logic             over_o,
  output logic             done_o
);
  logic [CNT_W-1:0] res_q;
  logic             ovf_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= latch_i;
      if (latch_i) begin
        res_q <= val_i;
        ovf_q <= ovf_i;
      end
    end
  end

  assign result_o = res_q;
  assign over_o   = ovf_q;
  assign done_o   = done_q;

  // R5: outside a done pulse the result holds its value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int T1_TICKS  = 1000,
  parameter int T2_MAX    = 1023,
  parameter int RST_TICKS = 4,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             zero_cross_i,
  output logic             sw_input_o,
  output logic             sw_ref_o,
  output logic             sw_dump_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             over_o
);
  logic             rst_i_n;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_en, latch, ovf;
  phase_t           phase;

  dsadc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  dsadc_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr_i(cnt_clr), .en_i(cnt_en), .cnt_o(cnt)
  );

  dsadc_phase_ctrl #(
    .T1_TICKS(T1_TICKS), .T2_MAX(T2_MAX), .RST_TICKS(RST_TICKS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .start_i(start_i), .zero_i(zero_cross_i),
    .cnt_i(cnt), .phase_o(phase), .cnt_clr_o(cnt_clr), .cnt_en_o(cnt_en),
    .latch_o(latch), .ovf_o(ovf)
  );

  dsadc_result_reg #(.CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_i_n), .latch_i(latch), .val_i(cnt), .ovf_i(ovf),
    .result_o(result_o), .over_o(over_o), .done_o(done_o)
  );

  always_comb begin
    sw_input_o = (phase == PH_INTEG);
    sw_ref_o   = (phase == PH_DEINT);
    sw_dump_o  = (phase == PH_DISCH);
    busy_o     = (phase != PH_IDLE);
  end

  // R4: one switch while busy, none in idle
  a_r4_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sw_input_o, sw_ref_o, sw_dump_o}) == (busy_o ? 1 : 0));
  // R6: an overrange result is always the saturated count
  a_r6_sat: assert property (@(posedge clk) disable iff (!rst_n)
    over_o |-> result_o == CNT_W'(T2_MAX));
  // R3: a crossing in the reference phase latches the count and raises done
  a_r3_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ref_o && zero_cross_i) |=> done_o && sw_dump_o && result_o == $past(cnt));
  // R5: done only in the discharge phase
  a_r5_done_phase: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sw_dump_o);
endmodule

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T1   = 1000;
  localparam int T2M  = 1023;
  localparam int RSTT = 4;
  localparam int W    = 10;
  localparam longint REF = 800;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic zero_cross_i = 1'b0;
  logic sw_input_o, sw_ref_o, sw_dump_o, busy_o, done_o, over_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  dsadc_seq #(.T1_TICKS(T1), .T2_MAX(T2M), .RST_TICKS(RSTT), .CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_cross_i(zero_cross_i),
    .sw_input_o(sw_input_o), .sw_ref_o(sw_ref_o), .sw_dump_o(sw_dump_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .over_o(over_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input longint vin, input bit poke_start);
    longint acc = 0;
    int n_in = 0, n_ref = 0, n_dump = 0, n_busy = 0, n_done = 0;
    int bad_hot = 0, bad_hold = 0;
    logic [W-1:0] prev_res;
    logic prev_over;
    longint k, exp_res, exp_over, exp_ref;
    k = (vin * T1 + REF - 1) / REF;
    if (k <= T2M) begin exp_res = k; exp_over = 0; exp_ref = k + 1; end
    else          begin exp_res = T2M; exp_over = 1; exp_ref = T2M + 1; end
    @(negedge clk);
    prev_res  = result_o;
    prev_over = over_o;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) begin
      n_busy++;
      if ($countones({sw_input_o, sw_ref_o, sw_dump_o}) != 1) bad_hot++;
      if (sw_input_o) n_in++;
      if (sw_dump_o)  n_dump++;
      if (done_o) begin
        n_done++;
        check("R3/R6 result", result_o, exp_res);
        check("R6 over", over_o, exp_over);
        if (!sw_dump_o || n_dump != 1) bad_hold++;
      end else if (result_o != prev_res || over_o != prev_over) bad_hold++;
      prev_res  = result_o;
      prev_over = over_o;
      // integrator model driving the comparator for the coming edge
      zero_cross_i = 1'b0;
      if (sw_input_o) acc += vin;
      if (sw_ref_o) begin
        n_ref++;
        zero_cross_i = (acc <= 0);
        acc -= REF;
        if (poke_start && n_ref == 3) start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
    end
    zero_cross_i = 1'b0;
    check("R2 input-phase cycles", n_in, T1);
    check("R3 reference cycles", n_ref, exp_ref);
    check("R7 discharge cycles", n_dump, RSTT);
    check("R9 busy cycles", n_busy, T1 + exp_ref + RSTT);
    check("R5 done pulses", n_done, 1);
    check("R4 switch one-hot", bad_hot, 0);
    check("R5 result held", bad_hold, 0);
    // R7/R4: idle afterwards with all switches off
    check("R7 idle after", {busy_o, sw_input_o, sw_ref_o, sw_dump_o}, 0);
    if (poke_start) begin
      @(negedge clk);
      check("R8 stays idle after ignored start", busy_o, 0);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1 switches in reset", {sw_input_o, sw_ref_o, sw_dump_o}, 0);
    check("R1 flags in reset", {busy_o, done_o, over_o}, 0);
    check("R1 result in reset", result_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {busy_o, done_o, over_o, sw_input_o, sw_ref_o, sw_dump_o}, 0);
    check("R1 result after reset", result_o, 0);
    // small-input sweep
    for (int v = 0; v <= 24; v++) run_conv(v, 1'b0);
    run_conv(400, 1'b0);   // half scale -> 500
    run_conv(800, 1'b0);   // full scale -> 1000
    run_conv(818, 1'b0);   // exactly at the limit, no overrange
    run_conv(819, 1'b0);   // one past the limit
    run_conv(5, 1'b0);     // R6: overrange cleared by in-range result
    run_conv(1200, 1'b0);
    run_conv(37, 1'b1);    // R8: start pulse during reference phase
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule